// File: doc/BRIEF.md
# Multiplexed-Bus Flash ROM Read Controller

This block turns 32-bit read requests from on-chip logic into read cycles on a parallel Flash ROM that shares one 8-bit bus between address and data. For every request the controller puts the three bytes of a 20-bit address on the bus one at a time. Each byte goes into its own external 8-bit latch through a dedicated strobe. The controller then releases the bus and reads one, two or four bytes. A word or dword access needs more than one byte. Between those bytes only the low address byte is incremented and latched again. The bytes are packed little-endian into a 32-bit response.

The address is aligned to the access size and clipped to a ROM window. Two strap bits on the bus select the window size when reset is released. The request side is a valid/ready port. The requester holds `req_valid`, `req_addr` and `req_size` steady until a clock edge where `req_ready` is high. `req_ready` is high only when the controller is idle, so at most one request is in flight. The response is a one-cycle `rsp_valid` pulse with no back-pressure. The requester must be able to take it in that cycle.

Top module: `flash_mux_ctrl`

## Requirements
- R1: While reset is asserted, the bus is not driven, no strobe is active and `req_ready` is low. On the first clock edge after release, `bus_in[2:1]` is captured as the window code, and `req_ready` rises after that edge.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, and it drops after an acceptance until the response has been delivered.
- R3: The address bytes go out in this order: low (`lat_stb[0]`, address bits 7:0), middle (`lat_stb[1]`, bits 15:8), high (`lat_stb[2]`, bits 19:16 in bus bits 3:0 with the upper bus bits zero). Each strobe is high for exactly one clock while its byte is on the bus. The bus stays driven with the same byte for the next clock.
- R4: `req_size` encodes 00 = byte, 01 = word, 10 = dword, 11 = dword. A word access clears address bit 0. A dword access clears address bits 1:0. A byte access keeps the address as given.
- R5: After the address phases there is one cycle with `bus_oe` low. Then `rom_rd` is high for 3 clocks per byte, and the byte is sampled on the last of them. `bus_oe` is never high while `rom_rd` is high.
- R6: In a multi-byte access, the low address byte is incremented before each following byte, and only `lat_stb[0]` pulses again. Per request, `lat_stb[0]` pulses once per byte, and `lat_stb[1]` and `lat_stb[2]` pulse once each.
- R7: Response bits 7:0 hold the byte at the lowest address and later bytes fill the higher lanes. Bits above the accessed width carry no defined value.
- R8: `rsp_valid` is a single-cycle pulse. It rises 10, 16 or 28 clock edges after the accepting edge for a byte, word or dword access.
- R9: The window code selects 00 = 64 KB, 01 = 128 KB, 10 = 512 KB and 11 = 1 MB. Address bits at or above the window size are driven as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | 20 | Byte address of the request |
| req_size | input | 2 | Access size code |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 32 | Packed read data, little-endian |
| bus_in | input | 8 | Value sensed on the shared bus |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus driver enable |
| lat_stb | output | 3 | Address latch strobes, bit 0 for the low byte |
| rom_rd | output | 1 | ROM read strobe |

## Verification
The properties assume the requester obeys the handshake: it does not change a pending request before acceptance, and it never needs `rsp_valid` to wait. They also assume reset lasts at least one clock edge, with the strap value present on `bus_in` at the first edge after release. The stimulus meets these assumptions in several ways:
- It drives inputs only on falling edges.
- It holds each request until `req_ready` is seen high.
- It presents straps through a model of the bus that shows the strap value whenever the ROM is not reading.
- It reaches each window code through a fresh reset.

// File: rtl/flash_mux_pkg.sv
package flash_mux_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_DWALT = 2'b11
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASTB,
    ST_AHLD,
    ST_TURN,
    ST_READ,
    ST_DONE
  } ctl_state_e;

  // index of the last byte lane used by an access of the given size
  function automatic logic [1:0] last_lane(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 2'd0;
      SZ_WORD: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/fmc_window_sense.sv
module fmc_window_sense #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sense_in,
  output logic              sensed,
  output logic [ADDR_W-1:0] win_mask
);
  localparam int BITS_64K  = 16;
  localparam int BITS_128K = 17;
  localparam int BITS_512K = 19;
  localparam int BITS_1M   = 20;

  logic [1:0] code_q;
  logic       done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 2'b11;
      done_q <= 1'b0;
    end else if (!done_q) begin
      code_q <= sense_in;
      done_q <= 1'b1;
    end
  end

  int              nbits;
  logic [ADDR_W:0] one_sh;

  always_comb begin
    case (code_q)
      2'b00:   nbits = BITS_64K;
      2'b01:   nbits = BITS_128K;
      2'b10:   nbits = BITS_512K;
      default: nbits = BITS_1M;
    endcase
    if (nbits > ADDR_W) nbits = ADDR_W;
    one_sh   = (ADDR_W+1)'(1) << nbits;
    win_mask = one_sh[ADDR_W-1:0] - ADDR_W'(1);
  end

  assign sensed = done_q;

endmodule

// File: rtl/fmc_addr_align.sv
module fmc_addr_align
  import flash_mux_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] raw_addr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] win_mask,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] clipped;

  always_comb begin
    clipped = raw_addr & win_mask;
    case (acc_size_e'(size))
      SZ_BYTE: addr = clipped;
      SZ_WORD: addr = {clipped[ADDR_W-1:1], 1'b0};
      default: addr = {clipped[ADDR_W-1:2], 2'b00};
    endcase
  end

endmodule

// File: rtl/fmc_read_pack.sv
module fmc_read_pack #(
  parameter int BUS_W = 8,
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               cap_en,
  input  logic [IDX_W-1:0]   lane_idx,
  input  logic [BUS_W-1:0]   din,
  output logic [LANES*BUS_W-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BUS_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (clear)
        lane_q <= '0;
      else if (cap_en && lane_idx == IDX_W'(g))
        lane_q <= din;
    end
    assign dout[g*BUS_W +: BUS_W] = lane_q;
  end

endmodule

// File: rtl/flash_mux_ctrl.sv
module flash_mux_ctrl
  import flash_mux_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 8,
  parameter int DATA_W = 32,
  parameter int RD_CYC = 3,
  localparam int NADR  = (ADDR_W + BUS_W - 1) / BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic [NADR-1:0]   lat_stb,
  output logic              rom_rd
);
  localparam int LANES = DATA_W / BUS_W;
  localparam int IDX_W = $clog2(LANES);
  localparam int AIX_W = (NADR > 1) ? $clog2(NADR) : 1;
  localparam int CNT_W = $clog2(RD_CYC + 1);
  localparam int PAD_W = NADR * BUS_W;

  ctl_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AIX_W-1:0]  aidx_q;
  logic [IDX_W-1:0]  lane_q;
  logic [IDX_W-1:0]  last_q;
  logic [CNT_W-1:0]  rcnt_q;

  logic              sensed;
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] aligned;
  logic              accept;
  logic              cap_en;
  logic [PAD_W-1:0]  addr_pad;
  logic [1:0]        last_sz;

  fmc_window_sense #(.ADDR_W(ADDR_W)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .sense_in (bus_in[2:1]),
    .sensed   (sensed),
    .win_mask (win_mask)
  );

  fmc_addr_align #(.ADDR_W(ADDR_W)) u_align (
    .raw_addr (req_addr),
    .size     (req_size),
    .win_mask (win_mask),
    .addr     (aligned)
  );

  fmc_read_pack #(.BUS_W(BUS_W), .LANES(LANES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .cap_en   (cap_en),
    .lane_idx (lane_q),
    .din      (bus_in),
    .dout     (rsp_data)
  );

  assign req_ready = (st_q == ST_IDLE) && sensed;
  assign accept    = req_valid && req_ready;
  assign cap_en    = (st_q == ST_READ) && (rcnt_q == CNT_W'(RD_CYC - 1));
  assign last_sz   = last_lane(req_size);
  assign addr_pad  = PAD_W'(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      aidx_q <= '0;
      lane_q <= '0;
      last_q <= '0;
      rcnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q <= aligned;
            last_q <= IDX_W'(last_sz);
            lane_q <= '0;
            aidx_q <= '0;
            st_q   <= ST_ASTB;
          end
        end
        ST_ASTB: st_q <= ST_AHLD;
        ST_AHLD: begin
          if (aidx_q == AIX_W'(NADR - 1) || lane_q != '0) begin
            st_q <= ST_TURN;
          end else begin
            aidx_q <= aidx_q + AIX_W'(1);
            st_q   <= ST_ASTB;
          end
        end
        ST_TURN: begin
          rcnt_q <= '0;
          st_q   <= ST_READ;
        end
        ST_READ: begin
          if (cap_en) begin
            if (lane_q == last_q) begin
              st_q <= ST_DONE;
            end else begin
              lane_q              <= lane_q + IDX_W'(1);
              addr_q[BUS_W-1:0]   <= addr_q[BUS_W-1:0] + BUS_W'(1);
              aidx_q              <= '0;
              st_q                <= ST_ASTB;
            end
          end else begin
            rcnt_q <= rcnt_q + CNT_W'(1);
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_oe  = (st_q == ST_ASTB) || (st_q == ST_AHLD);
    bus_out = bus_oe ? addr_pad[aidx_q*BUS_W +: BUS_W] : '0;
    lat_stb = '0;
    if (st_q == ST_ASTB) lat_stb[aidx_q] = 1'b1;
    rom_rd    = (st_q == ST_READ);
    rsp_valid = (st_q == ST_DONE);
  end

endmodule

// File: rtl/fmc_checker.sv
module fmc_checker #(
  parameter int BUS_W = 8,
  parameter int NADR  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [BUS_W-1:0] bus_out,
  input logic             bus_oe,
  input logic [NADR-1:0]  lat_stb,
  input logic             rom_rd
);
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(bus_oe || rom_rd || rsp_valid));

  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lat_stb, rom_rd}));

  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|lat_stb) |=> !(|lat_stb));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|lat_stb) |-> bus_oe ##1 (bus_oe && $stable(bus_out)));

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> !bus_oe);

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_rd) |-> !$past(bus_oe));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind flash_mux_ctrl fmc_checker #(.BUS_W(BUS_W), .NADR(NADR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_out   (bus_out),
  .bus_oe    (bus_oe),
  .lat_stb   (lat_stb),
  .rom_rd    (rom_rd)
);

// File: tb/tb_flash_mux_ctrl.sv
module tb_flash_mux_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [7:0]  bus_in;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [2:0]  lat_stb;
  logic        rom_rd;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  logic [1:0] strap = 2'b11;
  logic [7:0] lat0 = '0, lat1 = '0, lat2 = '0;

  always #4 clk = ~clk;

  flash_mux_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .lat_stb(lat_stb), .rom_rd(rom_rd)
  );

  function automatic logic [7:0] mem_f(input logic [19:0] a);
    return a[7:0] + 8'(a[15:8] * 3) + 8'(a[19:16] * 17);
  endfunction

  // external latches and ROM model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (lat_stb[0]) lat0 <= bus_out;
    if (lat_stb[1]) lat1 <= bus_out;
    if (lat_stb[2]) lat2 <= bus_out;
  end
  assign bus_in = rom_rd ? mem_f({lat2[3:0], lat1, lat0}) : {5'b0, strap, 1'b0};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [31:0] q_data[$];
  int          q_bytes[$];
  int          q_acc[$];

  task automatic do_req(input logic [19:0] a, input logic [1:0] sz);
    int nb;
    int wb;
    logic [19:0] m;
    logic [19:0] al;
    logic [31:0] ex;
    nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    case (strap)
      2'b00:   wb = 16;
      2'b01:   wb = 17;
      2'b10:   wb = 19;
      default: wb = 20;
    endcase
    m  = 20'((21'd1 << wb) - 21'd1);
    al = a & m;                                   // R9 window clip
    if (nb == 2) al[0] = 1'b0;                    // R4 word align
    if (nb == 4) al[1:0] = 2'b00;                 // R4 dword align
    ex = '0;
    for (int k = 0; k < nb; k++) ex[8*k +: 8] = mem_f(al + 20'(k));  // R7 little-endian
    req_valid = 1'b1;
    req_addr  = a;
    req_size  = sz;
    while (!req_ready) @(negedge clk);
    q_data.push_back(ex);
    q_bytes.push_back(nb);
    q_acc.push_back(cyc + 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  int  n_lo = 0, n_mid = 0, n_hi = 0, n_rd = 0;
  bit  busy_ready = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      n_lo = 0; n_mid = 0; n_hi = 0; n_rd = 0; busy_ready = 0;
    end else begin
      if (lat_stb[0]) n_lo++;
      if (lat_stb[1]) n_mid++;
      if (lat_stb[2]) n_hi++;
      if (rom_rd) n_rd++;
      if (q_acc.size() != 0 && cyc >= q_acc[0] && req_ready) busy_ready = 1;
      if (rsp_valid) begin
        if (q_data.size() == 0) begin
          chk(0, "R8 unexpected response", 1, 0);
        end else begin
          logic [31:0] ex;
          logic [31:0] wm;
          int nb;
          int lat;
          int elat;
          ex = q_data.pop_front();
          nb = q_bytes.pop_front();
          lat = cyc - q_acc.pop_front();
          wm = (nb == 4) ? 32'hFFFF_FFFF : (nb == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
          elat = 10 + 6 * (nb - 1);
          chk((rsp_data & wm) == ex, "R7 R4 R9 read data", rsp_data & wm, ex);
          chk(lat == elat, "R8 latency", lat, elat);
          chk(n_lo == nb, "R6 low latch strobes", n_lo, nb);
          chk(n_mid == 1 && n_hi == 1, "R3 R6 upper latch strobes",
              {n_mid[15:0], n_hi[15:0]}, 32'h0001_0001);
          chk(n_rd == 3 * nb, "R5 read strobe cycles", n_rd, 3 * nb);
          chk(!busy_ready, "R2 ready while busy", busy_ready, 0);
        end
        n_lo = 0; n_mid = 0; n_hi = 0; n_rd = 0; busy_ready = 0;
      end
    end
  end

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    repeat (3) @(negedge clk);
    chk(!bus_oe && lat_stb == 3'b0 && !rom_rd && !req_ready, "R1 quiet in reset",
        {bus_oe, lat_stb, rom_rd, req_ready}, 0);
    rst_n = 1'b1;
    #1;
    chk(!req_ready, "R1 ready low before sense edge", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R1 ready after sense edge", req_ready, 1);
  endtask

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // 1 MB window (R9 code 11)
    do_reset(2'b11);
    do_req(20'h12345, 2'b00);
    do_req(20'h54321, 2'b01);       // R4 word align -> 0x54320
    do_req(20'hABCDE, 2'b10);       // R4 dword align -> 0xABCDC
    do_req(20'hFFFFF, 2'b11);       // R4 code 11 as dword
    do_req(20'h000FD, 2'b10);
    drain();
    // 64 KB window
    do_reset(2'b00);
    do_req(20'hF1234, 2'b00);       // R9 -> 0x01234
    do_req(20'h3FFFF, 2'b10);       // R9 -> 0x0FFFC
    drain();
    // 128 KB window
    do_reset(2'b01);
    do_req(20'h30001, 2'b01);       // R9 -> 0x10000
    drain();
    // 512 KB window
    do_reset(2'b10);
    do_req(20'hFFFFF, 2'b00);       // R9 -> 0x7FFFF
    do_req(20'hC8003, 2'b01);       // R9 R4 -> 0x48002
    drain();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule